// File: doc/BRIEF.md
# Serial FIFO interrupt status unit

This block gathers the status conditions of a synchronous serial port that has transmit and receive FIFOs and produces a single interrupt line from them. Each cycle it samples the FIFO levels and flags, the push and pop strobes, the slot and bit timing strobes, the frame-sync pulse and the slot configuration. From these it builds a 12-bit status word. Six bits of that word follow live conditions. The other six record error events and hold them until software clears them.

A 12-bit enable register selects which status bits drive the interrupt. Software reaches both registers through a one-bit-address read/write port. Status sits at address 0 and enable at address 1. Writing a 1 to an error bit at address 0 clears that bit. The live bits ignore writes.

Top module: `sfifo_irq_unit`

## Requirements
- R1: While `rst_n` is low, the status word, the enable register and `irq` all read 0.
- R2: Status bit map: 0 receive request, 1 receive full, 2 transmit request, 3 transmit empty, 4 receive control valid, 5 transmit control ready, 6 receive overflow, 7 receive underflow, 8 transmit overflow, 9 transmit underflow, 10 sync error, 11 slot clash. `irq` is high exactly when some status bit and the same enable bit are both 1.
- R3: One cycle after the inputs are sampled, bit 0 equals (`rx_level` >= `rx_thresh`) and bit 2 equals (DEPTH - `tx_level` >= `tx_thresh`).
- R4: Bits 1, 3, 4 and 5 repeat `rx_full`, `tx_empty`, `rctl_valid` and `tctl_ready` one cycle later.
- R5: A cycle with `tx_slot` and `tx_empty` both high sets bit 9, which then stays set.
- R6: Three events each set a bit that then stays set: `rx_push` with `rx_full` sets bit 6, `rx_pop` with `rx_empty` sets bit 7, and `tx_push` with `tx_full` sets bit 8. A strobe arriving without its flag sets nothing.
- R7: Bit 10 is set when `fsync` arrives in slave mode after an earlier `fsync` and fewer than `frame_bits` `bit_tick` strobes have been counted since that earlier one. It is never set with `slave_mode` low.
- R8: Bit 11 is set while both slot assignments are enabled and `data_slot` equals `ctrl_slot`.
- R9: A write to address 0 clears each error bit (11..6) whose data bit is 1. Error bits written with 0 are unchanged, and the live bits (5..0) are unaffected.
- R10: If a clearing write and a new event for the same error bit fall in one cycle, the bit ends up set.
- R11: A write to address 1 loads all 12 bits of enable. `reg_rdata` shows status for address 0 and enable for address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_thresh | input | LVL_W | Free-space threshold for transmit request |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_thresh | input | LVL_W | Fill threshold for receive request |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| tx_push | input | 1 | Write into transmit FIFO |
| rx_push | input | 1 | Serial word arriving for receive FIFO |
| rx_pop | input | 1 | Read from receive FIFO |
| tx_slot | input | 1 | Transmit slot time strobe |
| bit_tick | input | 1 | One serial bit elapsed |
| fsync | input | 1 | Frame-sync pulse |
| slave_mode | input | 1 | Port runs with external frame sync |
| frame_bits | input | BCNT_W | Bits expected per frame |
| data_slot | input | SLOT_W | Slot number of data |
| data_slot_on | input | 1 | Data slot assignment in use |
| ctrl_slot | input | SLOT_W | Slot number of control |
| ctrl_slot_on | input | 1 | Control slot assignment in use |
| tctl_ready | input | 1 | Transmit control register writable |
| rctl_valid | input | 1 | Receive control register holds data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 status, 1 enable |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with LVL_W=3, DEPTH=4, SLOT_W=2 and BCNT_W=4. With those values it can sweep every FIFO level against every threshold, every pair of data and control slots, and every strobe-and-flag combination of the four FIFO events. A frame of five bits lets it place a sync pulse before, at and after the frame boundary, and the twelve enable bits are walked one at a time against a known status pattern.

// File: rtl/sfifo_irq_pkg.sv
package sfifo_irq_pkg;
    localparam int NSRC   = 12;
    localparam int NLIVE  = 6;
    localparam int NERR   = NSRC - NLIVE;

    localparam int B_RX_REQ   = 0;
    localparam int B_RX_FULL  = 1;
    localparam int B_TX_REQ   = 2;
    localparam int B_TX_EMPTY = 3;
    localparam int B_RCTL     = 4;
    localparam int B_TCTL     = 5;
    localparam int B_RX_OVF   = 6;
    localparam int B_RX_UDF   = 7;
    localparam int B_TX_OVF   = 8;
    localparam int B_TX_UDF   = 9;
    localparam int B_SYNC     = 10;
    localparam int B_CLASH    = 11;

    localparam logic A_STATUS = 1'b0;
    localparam logic A_ENABLE = 1'b1;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [NLIVE-1:0] live_vec_t;
    typedef logic [NERR-1:0]  err_vec_t;

    typedef struct packed {
        err_vec_t  err;
        live_vec_t live;
        src_vec_t  en;
    } bank_t;
endpackage

// File: rtl/sfifo_irq_live.sv
module sfifo_irq_live
    import sfifo_irq_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int DEPTH = 16
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic             tx_empty,
    input  logic             rx_full,
    input  logic             tctl_ready,
    input  logic             rctl_valid,
    output live_vec_t        live
);
    localparam int CMP_W = LVL_W + 1;

    logic [CMP_W-1:0] tx_free;

    always_comb begin
        tx_free          = CMP_W'(DEPTH) - {1'b0, tx_level};
        live             = '0;
        live[B_RX_REQ]   = (rx_level >= rx_thresh);
        live[B_RX_FULL]  = rx_full;
        live[B_TX_REQ]   = (tx_free >= {1'b0, tx_thresh});
        live[B_TX_EMPTY] = tx_empty;
        live[B_RCTL]     = rctl_valid;
        live[B_TCTL]     = tctl_ready;
    end
endmodule

// File: rtl/sfifo_irq_sync.sv
module sfifo_irq_sync #(
    parameter int BCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              fsync,
    input  logic              slave_mode,
    input  logic [BCNT_W-1:0] frame_bits,
    output logic              sync_err
);
    typedef struct packed {
        logic [BCNT_W-1:0] cnt;
        logic              armed;
    } frm_t;

    frm_t frm_d, frm_q;

    always_comb begin
        frm_d    = frm_q;
        sync_err = fsync && slave_mode && frm_q.armed && (frm_q.cnt < frame_bits);
        if (fsync) begin
            frm_d.armed = 1'b1;
            frm_d.cnt   = BCNT_W'(bit_tick);
        end else if (bit_tick && (frm_q.cnt != '1)) begin
            frm_d.cnt = frm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end
endmodule

// File: rtl/sfifo_irq_evt.sv
module sfifo_irq_evt
    import sfifo_irq_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic              tx_push,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              tx_slot,
    input  logic              sync_err,
    input  logic [SLOT_W-1:0] data_slot,
    input  logic              data_slot_on,
    input  logic [SLOT_W-1:0] ctrl_slot,
    input  logic              ctrl_slot_on,
    output err_vec_t          evt
);
    always_comb begin
        evt                      = '0;
        evt[B_RX_OVF - NLIVE]    = rx_push && rx_full;
        evt[B_RX_UDF - NLIVE]    = rx_pop && rx_empty;
        evt[B_TX_OVF - NLIVE]    = tx_push && tx_full;
        evt[B_TX_UDF - NLIVE]    = tx_slot && tx_empty;
        evt[B_SYNC - NLIVE]      = sync_err;
        evt[B_CLASH - NLIVE]     = data_slot_on && ctrl_slot_on && (data_slot == ctrl_slot);
    end
endmodule

// File: rtl/sfifo_irq_unit.sv
module sfifo_irq_unit
    import sfifo_irq_pkg::*;
#(
    parameter int LVL_W  = 5,
    parameter int DEPTH  = 16,
    parameter int SLOT_W = 5,
    parameter int BCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  tx_thresh,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  rx_thresh,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic              tx_push,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              tx_slot,
    input  logic              bit_tick,
    input  logic              fsync,
    input  logic              slave_mode,
    input  logic [BCNT_W-1:0] frame_bits,
    input  logic [SLOT_W-1:0] data_slot,
    input  logic              data_slot_on,
    input  logic [SLOT_W-1:0] ctrl_slot,
    input  logic              ctrl_slot_on,
    input  logic              tctl_ready,
    input  logic              rctl_valid,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [NSRC-1:0]   reg_rdata,
    output logic              irq
);
    live_vec_t live;
    err_vec_t  evt;
    err_vec_t  clr;
    err_vec_t  err_next;
    logic      sync_err;
    bank_t     bank_d, bank_q;

    sfifo_irq_live #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_live (
        .tx_level  (tx_level),
        .tx_thresh (tx_thresh),
        .rx_level  (rx_level),
        .rx_thresh (rx_thresh),
        .tx_empty  (tx_empty),
        .rx_full   (rx_full),
        .tctl_ready(tctl_ready),
        .rctl_valid(rctl_valid),
        .live      (live)
    );

    sfifo_irq_sync #(.BCNT_W(BCNT_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .fsync     (fsync),
        .slave_mode(slave_mode),
        .frame_bits(frame_bits),
        .sync_err  (sync_err)
    );

    sfifo_irq_evt #(.SLOT_W(SLOT_W)) u_evt (
        .tx_empty    (tx_empty),
        .tx_full     (tx_full),
        .rx_empty    (rx_empty),
        .rx_full     (rx_full),
        .tx_push     (tx_push),
        .rx_push     (rx_push),
        .rx_pop      (rx_pop),
        .tx_slot     (tx_slot),
        .sync_err    (sync_err),
        .data_slot   (data_slot),
        .data_slot_on(data_slot_on),
        .ctrl_slot   (ctrl_slot),
        .ctrl_slot_on(ctrl_slot_on),
        .evt         (evt)
    );

    assign clr = (reg_wr && (reg_addr == A_STATUS)) ? reg_wdata[NSRC-1:NLIVE] : '0;

    // Per-bit sticky update: a fresh event outranks a clear in the same cycle.
    for (genvar g = 0; g < NERR; g++) begin : g_sticky
        assign err_next[g] = evt[g] | (bank_q.err[g] & ~clr[g]);
    end

    always_comb begin
        bank_d      = bank_q;
        bank_d.live = live;
        bank_d.err  = err_next;
        if (reg_wr && (reg_addr == A_ENABLE)) bank_d.en = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        reg_rdata = (reg_addr == A_ENABLE) ? bank_q.en : {bank_q.err, bank_q.live};
        irq       = |({bank_q.err, bank_q.live} & bank_q.en);
    end
endmodule

// File: rtl/sfifo_irq_chk.sv
module sfifo_irq_chk
    import sfifo_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            irq,
    input logic [NSRC-1:0] status,
    input logic [NSRC-1:0] enable,
    input logic            tx_slot,
    input logic            tx_empty,
    input logic            rx_push,
    input logic            rx_full,
    input logic            slave_mode,
    input logic            reg_wr,
    input logic            reg_addr,
    input logic [NSRC-1:0] reg_wdata
);
    logic           clr_wr;
    logic [NERR-1:0] keep;

    always_comb begin
        clr_wr = reg_wr && (reg_addr == A_STATUS);
        keep   = status[NSRC-1:NLIVE] & ~(clr_wr ? reg_wdata[NSRC-1:NLIVE] : '0);
    end

    p_irq_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);

    p_irq_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    p_tx_udf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_slot && tx_empty) |=> status[B_TX_UDF]);

    p_rx_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> status[B_RX_OVF]);

    p_sync_slave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[B_SYNC]) |-> $past(slave_mode));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status[NSRC-1:NLIVE] & $past(keep)) == $past(keep)));

    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && clr_wr && reg_wdata[B_RX_OVF]) |=> status[B_RX_OVF]);

    p_en_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_ENABLE)) |=> (enable == $past(reg_wdata)));
endmodule

bind sfifo_irq_unit sfifo_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .status    ({bank_q.err, bank_q.live}),
    .enable    (bank_q.en),
    .tx_slot   (tx_slot),
    .tx_empty  (tx_empty),
    .rx_push   (rx_push),
    .rx_full   (rx_full),
    .slave_mode(slave_mode),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/tb_sfifo_irq_unit.sv
`timescale 1ns/1ps
module tb_sfifo_irq_unit;
    localparam int LVL_W = 3, DEPTH = 4, SLOT_W = 2, BCNT_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [LVL_W-1:0] tx_level, tx_thresh, rx_level, rx_thresh;
    logic tx_empty, tx_full, rx_empty, rx_full, tx_push, rx_push, rx_pop, tx_slot;
    logic bit_tick, fsync, slave_mode;
    logic [BCNT_W-1:0] frame_bits;
    logic [SLOT_W-1:0] data_slot, ctrl_slot;
    logic data_slot_on, ctrl_slot_on, tctl_ready, rctl_valid;
    logic reg_wr, reg_addr;
    logic [11:0] reg_wdata, reg_rdata;
    logic irq;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    sfifo_irq_unit #(.LVL_W(LVL_W), .DEPTH(DEPTH), .SLOT_W(SLOT_W), .BCNT_W(BCNT_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .tx_thresh(tx_thresh), .rx_level(rx_level), .rx_thresh(rx_thresh),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop), .tx_slot(tx_slot),
        .bit_tick(bit_tick), .fsync(fsync), .slave_mode(slave_mode), .frame_bits(frame_bits),
        .data_slot(data_slot), .data_slot_on(data_slot_on), .ctrl_slot(ctrl_slot),
        .ctrl_slot_on(ctrl_slot_on), .tctl_ready(tctl_ready), .rctl_valid(rctl_valid),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic a, output logic [11:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
        reg_addr = 1'b0;
        #0.1;
    endtask

    task automatic wr(input logic a, input logic [11:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    task automatic clear_errs();
        wr(1'b0, 12'hFC0);
    endtask

    task automatic idle_inputs();
        tx_level = '0; tx_thresh = '1; rx_level = '0; rx_thresh = '1;
        tx_empty = 0; tx_full = 0; rx_empty = 0; rx_full = 0;
        tx_push = 0; rx_push = 0; rx_pop = 0; tx_slot = 0;
        bit_tick = 0; fsync = 0; slave_mode = 0; frame_bits = '0;
        data_slot = '0; ctrl_slot = '0; data_slot_on = 0; ctrl_slot_on = 0;
        tctl_ready = 0; rctl_valid = 0;
        reg_wr = 0; reg_addr = 0; reg_wdata = '0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R1 got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [11:0] v;
        idle_inputs();
        tctl_ready = 1; rx_full = 1;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        rd(1'b0, v); check("R1 status in reset", v, 0);
        rd(1'b1, v); check("R1 enable in reset", v, 0);
        check("R1 irq in reset", irq, 0);
        idle_inputs();
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R3: level vs threshold sweep
        for (int lvl = 0; lvl <= DEPTH; lvl++) begin
            for (int th = 0; th < 8; th++) begin
                tx_level = LVL_W'(lvl); rx_level = LVL_W'(lvl);
                tx_thresh = LVL_W'(th); rx_thresh = LVL_W'(th);
                tick();
                rd(1'b0, v);
                check($sformatf("R3 rx req lvl=%0d th=%0d", lvl, th), v[0], int'(lvl >= th));
                check($sformatf("R3 tx req lvl=%0d th=%0d", lvl, th), v[2], int'(DEPTH - lvl >= th));
            end
        end
        idle_inputs();

        // R4: mirrored flags, R9: live bits ignore writes
        for (int c = 0; c < 16; c++) begin
            int exp_live;
            tx_empty = c[0]; rx_full = c[1]; rctl_valid = c[2]; tctl_ready = c[3];
            exp_live = (c[1] << 1) | (c[0] << 3) | (c[2] << 4) | (c[3] << 5);
            tick();
            rd(1'b0, v);
            check($sformatf("R4 live flags combo %0d", c), v, exp_live);
            wr(1'b0, 12'hFFF);
            rd(1'b0, v);
            check($sformatf("R9 live bits after write combo %0d", c), v, exp_live);
        end
        idle_inputs();
        tick();

        // R5, R6: strobe/flag sweep of the four FIFO events, stickiness, selective clear
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 2; s++) begin
                for (int f = 0; f < 2; f++) begin
                    int exp_e;
                    string tg;
                    tg = (k == 3) ? "R5" : "R6";
                    case (k)
                        0: begin rx_push = s[0]; rx_full  = f[0]; end
                        1: begin rx_pop  = s[0]; rx_empty = f[0]; end
                        2: begin tx_push = s[0]; tx_full  = f[0]; end
                        default: begin tx_slot = s[0]; tx_empty = f[0]; end
                    endcase
                    exp_e = (s == 1 && f == 1) ? (1 << k) : 0;
                    tick();
                    idle_inputs();
                    rd(1'b0, v);
                    check($sformatf("%s event k=%0d s=%0d f=%0d", tg, k, s, f), v[11:6], exp_e);
                    tick();
                    rd(1'b0, v);
                    check($sformatf("%s held k=%0d s=%0d f=%0d", tg, k, s, f), v[11:6], exp_e);
                    if (exp_e != 0) begin
                        wr(1'b0, 12'hFC0 & ~(12'(1) << (k + 6)));
                        rd(1'b0, v);
                        check($sformatf("R9 other-bit clear keeps k=%0d", k), v[11:6], exp_e);
                    end
                    clear_errs();
                    rd(1'b0, v);
                    check($sformatf("R9 cleared k=%0d s=%0d f=%0d", k, s, f), v[11:6], 0);
                end
            end
        end

        // R8: slot clash sweep
        for (int ds = 0; ds < 4; ds++) begin
            for (int cs = 0; cs < 4; cs++) begin
                for (int on = 1; on < 4; on++) begin
                    data_slot = SLOT_W'(ds); ctrl_slot = SLOT_W'(cs);
                    data_slot_on = on[0]; ctrl_slot_on = on[1];
                    tick();
                    data_slot_on = 0; ctrl_slot_on = 0;
                    rd(1'b0, v);
                    check($sformatf("R8 clash ds=%0d cs=%0d on=%0d", ds, cs, on),
                          v[11], int'(ds == cs && on == 3));
                    clear_errs();
                end
            end
        end
        idle_inputs();

        // R7: frame sync timing in slave mode, frame of 5 bits
        slave_mode = 1; frame_bits = 4'd5;
        fsync = 1; tick(); fsync = 0;
        rd(1'b0, v); check("R7 first sync no error", v[10], 0);
        for (int n = 0; n < 8; n++) begin
            for (int t = 0; t < n; t++) begin
                bit_tick = 1; tick();
            end
            bit_tick = 0; fsync = 1; tick(); fsync = 0;
            rd(1'b0, v);
            check($sformatf("R7 sync after %0d bits", n), v[10], int'(n < 5));
            clear_errs();
        end
        slave_mode = 0;
        bit_tick = 1; tick(); tick(); bit_tick = 0;
        fsync = 1; tick(); fsync = 0;
        rd(1'b0, v); check("R7 master mode short frame", v[10], 0);
        idle_inputs();
        clear_errs();

        // R10: event and clear in the same cycle
        tx_push = 1; tx_full = 1; tick(); idle_inputs();
        rx_push = 1; rx_full = 1;
        reg_wr = 1; reg_addr = 0; reg_wdata = 12'hFC0;
        tick();
        idle_inputs();
        rd(1'b0, v);
        check("R10 event beats clear", v[11:6], 6'b000001);
        clear_errs();

        // R2, R11: walk enable bits against a known status pattern
        rx_full = 1; tctl_ready = 1;
        rx_pop = 1; rx_empty = 1; tick(); rx_pop = 0; rx_empty = 0;
        rd(1'b0, v);
        check("R2 pattern", v, 12'h0A2);
        for (int i = 0; i < 12; i++) begin
            wr(1'b1, 12'(1) << i);
            rd(1'b1, v);
            check($sformatf("R11 enable readback bit %0d", i), v, 1 << i);
            check($sformatf("R2 irq enable bit %0d", i), irq, (12'h0A2 >> i) & 1);
        end
        wr(1'b1, 12'hFFF);
        check("R2 irq all enabled", irq, 1);
        rx_full = 0; tctl_ready = 0;
        clear_errs();
        rd(1'b0, v);
        check("R2 status cleared", v, 0);
        check("R2 irq with empty status", irq, 0);
        wr(1'b1, 12'h000);
        rd(1'b1, v);
        check("R11 enable zero", v, 0);

        finish_run();
    end
endmodule